// File: doc/BRIEF.md
# Crosspoint Switch Connection Loader

This block is the digital control front end of a 32-input, 16-output crosspoint switch. It keeps one 6-bit connection word for every output in two ranks of storage. A staging rank accepts new settings. A live rank drives the switch decoders. The staging rank can be filled in two ways. The first is a serial shift chain clocked by the falling edges of a serial clock; its far end comes out on a pin, so several devices can be daisy-chained. The second is an addressed write of a single output's word on the falling edge of a write strobe.

A separate active-low transfer strobe copies the staging rank into the live rank. The live rank follows the staging rank for as long as that strobe is low, and it holds while the strobe is high. A clear input disables every output. It also empties the staging rank, so a later transfer cannot bring back old connections.

Each live word is decoded into a one-hot 32-way input select and an output enable. Bit 5 of a word is the enable, and bits 4 to 0 give the input number. All control pins are asynchronous to the system clock. They pass through synchronizers, and the strobe edges are detected in the clock domain.

All control pins are plain levels and strobes with no valid/ready handshake. The programming host paces itself by the strobe timing, so the block applies no back-pressure.

Top module: `xpt_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further stimulus, every `out_en_o` bit and every `in_sel_o` bit is 0, and `ser_do_o` is 0.
- R2: With `mode_ser_i` = 1, each falling edge of `ser_clk_i` shifts the level on `ser_di_i` into the staging chain. The stream order runs from output 15 bit 5 first down to output 0 bit 0 last, so after 96 edges the first bit sent occupies output 15 bit 5.
- R3: `ser_do_o` shows the staging-chain bit that the next shift pushes out. Once 96 bits are in the chain, the next 96 edges bring the earlier stream back out in the order it was sent.
- R4: With `mode_ser_i` = 0, a falling edge of `wr_n_i` writes `wr_word_i` into the staging word of output `wr_addr_i`. The other 15 staging words do not change.
- R5: Falling edges of `ser_clk_i` have no effect on the staging rank in parallel mode, and falling edges of `wr_n_i` have no effect on it in serial mode.
- R6: While `upd_n_i` is low, the live rank copies the staging rank on every clock. While `upd_n_i` is high, the live rank holds its value even when the staging rank changes.
- R7: While `clr_n_i` is low, every output is disabled, whatever the state of the staging rank and of `upd_n_i`. After the clear ends, a transfer with no new writes leaves every output disabled.
- R8: For each output k, `in_sel_o[32k+31:32k]` has exactly bit i set when live bit 5 is 1 and live bits 4..0 equal i. It is all zeros when live bit 5 is 0, whatever the index bits hold.
- R9: `out_en_o[k]` equals bit 5 of live word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mode_ser_i | input | 1 | Load mode: 1 = serial chain, 0 = addressed write |
| ser_clk_i | input | 1 | Serial shift clock; data is taken on its falling edge |
| ser_di_i | input | 1 | Serial data into the chain |
| ser_do_o | output | 1 | Bit at the far end of the chain, for daisy-chaining |
| wr_n_i | input | 1 | Addressed write strobe; the write happens on its falling edge |
| wr_addr_i | input | 4 | Output number for an addressed write |
| wr_word_i | input | 6 | Connection word for an addressed write ({enable, input index}) |
| upd_n_i | input | 1 | Transfer strobe; the live rank is transparent while it is low |
| clr_n_i | input | 1 | Active-low clear of both ranks |
| in_sel_o | output | 512 | One-hot input select, 32 bits per output, output 0 in the low bits |
| out_en_o | output | 16 | Per-output enable |

## Verification
The hardest state to reach from the ports is a staging rank that differs from the live rank while the transfer strobe is high. Only in that state can a missing hold be seen. The stimulus gets there by loading new words through both load paths after a transfer has ended, then checking that the outputs still show the old connections. The chain output is checked by shifting a second 96-bit stream through the chain and comparing every outgoing bit with the first stream. The stale-data case for the clear is reached by clearing after a full load and then transferring with no writes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  // Width of one connection word for a given input count: index plus enable.
  function automatic int word_width(input int n_in);
    return $clog2(n_in) + 1;
  endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xpt_first_rank.sv
module xpt_first_rank #(
  parameter int N_OUT  = 16,
  parameter int WORD_W = 6,
  parameter int ADDR_W = 4,
  localparam int TOTAL = N_OUT * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [TOTAL-1:0]  rank_o,
  output logic              chain_out_o
);

  logic [TOTAL-1:0] rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rank_q <= '0;
    end else if (shift_en) begin
      rank_q <= {rank_q[TOTAL-2:0], shift_bit};
    end else if (wr_en) begin
      for (int k = 0; k < N_OUT; k++) begin
        if (wr_addr == ADDR_W'(k)) rank_q[k*WORD_W +: WORD_W] <= wr_word;
      end
    end
  end

  assign rank_o      = rank_q;
  assign chain_out_o = rank_q[TOTAL-1];

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> rank_q[0] == $past(shift_bit));

  a_r3_shift_along: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> rank_q[TOTAL-1:1] == $past(rank_q[TOTAL-2:0]));

  a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rank_q == '0);

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wr_en && !clr) |=> $stable(rank_q));

  for (genvar k = 0; k < N_OUT; k++) begin : g_word_chk
    a_r4_other_words: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !shift_en && !clr && wr_addr != ADDR_W'(k))
        |=> $stable(rank_q[k*WORD_W +: WORD_W]));
  end

endmodule

// File: rtl/xpt_live_rank.sv
module xpt_live_rank #(
  parameter int TOTAL = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             xfer,
  input  logic [TOTAL-1:0] first_i,
  output logic [TOTAL-1:0] live_o
);

  logic [TOTAL-1:0] live_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) live_q <= '0;
    else if (xfer)     live_q <= first_i;
  end

  assign live_o = live_q;

  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !clr) |=> live_q == $past(first_i));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !clr) |=> $stable(live_q));

  a_r7_clear_live: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> live_q == '0);

endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
  parameter int N_OUT  = 16,
  parameter int N_IN   = 32,
  parameter int WORD_W = 6,
  localparam int IDX_W = WORD_W - 1
) (
  input  logic [N_OUT*WORD_W-1:0] live_i,
  output logic [N_OUT*N_IN-1:0]   sel_o,
  output logic [N_OUT-1:0]        en_o
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_row
    logic [WORD_W-1:0] word;
    logic [N_IN-1:0]   row;

    assign word = live_i[k*WORD_W +: WORD_W];

    always_comb begin
      row = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (word[WORD_W-1] && word[IDX_W-1:0] == IDX_W'(i)) row[i] = 1'b1;
      end
    end

    assign sel_o[k*N_IN +: N_IN] = row;
    assign en_o[k]               = word[WORD_W-1];
  end

endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int N_OUT       = 16,
  parameter int N_IN        = 32,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = xpt_pkg::word_width(N_IN),
  localparam int ADDR_W     = $clog2(N_OUT),
  localparam int TOTAL      = N_OUT * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_ser_i,
  input  logic                    ser_clk_i,
  input  logic                    ser_di_i,
  output logic                    ser_do_o,
  input  logic                    wr_n_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [WORD_W-1:0]       wr_word_i,
  input  logic                    upd_n_i,
  input  logic                    clr_n_i,
  output logic [N_OUT*N_IN-1:0]   in_sel_o,
  output logic [N_OUT-1:0]        out_en_o
);

  import xpt_pkg::*;

  localparam int STB_W = 4;
  localparam int DAT_W = 2 + ADDR_W + WORD_W;

  // Strobes idle high; they synchronize with an all-ones reset value.
  logic [STB_W-1:0] stb_raw, stb_s;
  logic [DAT_W-1:0] dat_raw, dat_s;

  assign stb_raw = {ser_clk_i, wr_n_i, upd_n_i, clr_n_i};
  assign dat_raw = {mode_ser_i, ser_di_i, wr_addr_i, wr_word_i};

  xpt_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s));

  xpt_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(dat_raw), .q(dat_s));

  logic              sclk_s, wr_n_s, upd_n_s, clr_n_s;
  load_mode_e        mode_s;
  logic              sdi_s;
  logic [ADDR_W-1:0] addr_s;
  logic [WORD_W-1:0] word_s;

  assign {sclk_s, wr_n_s, upd_n_s, clr_n_s} = stb_s;
  assign mode_s = load_mode_e'(dat_s[DAT_W-1]);
  assign sdi_s  = dat_s[DAT_W-2];
  assign addr_s = dat_s[WORD_W +: ADDR_W];
  assign word_s = dat_s[WORD_W-1:0];

  // Falling-edge detection in the clock domain.
  logic sclk_d, wr_n_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      wr_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      wr_n_d <= wr_n_s;
    end
  end

  logic shift_fire, wr_fire, clr, xfer;
  assign shift_fire = sclk_d & ~sclk_s & (mode_s == LOAD_SER);
  assign wr_fire    = wr_n_d & ~wr_n_s & (mode_s == LOAD_PAR);
  assign clr        = ~clr_n_s;
  assign xfer       = ~upd_n_s;

  logic [TOTAL-1:0] first_rank, live_rank;

  xpt_first_rank #(.N_OUT(N_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_first (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .shift_en(shift_fire), .shift_bit(sdi_s),
    .wr_en(wr_fire), .wr_addr(addr_s), .wr_word(word_s),
    .rank_o(first_rank), .chain_out_o(ser_do_o));

  xpt_live_rank #(.TOTAL(TOTAL)) u_live (
    .clk(clk), .rst_n(rst_n), .clr(clr), .xfer(xfer),
    .first_i(first_rank), .live_o(live_rank));

  xpt_decode #(.N_OUT(N_OUT), .N_IN(N_IN), .WORD_W(WORD_W)) u_dec (
    .live_i(live_rank), .sel_o(in_sel_o), .en_o(out_en_o));

  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_fire && wr_fire));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (out_en_o == '0 && in_sel_o == '0 && !ser_do_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_sel_chk
    a_r8_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_sel_o[k*N_IN +: N_IN]));
    a_r9_en_matches_row: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_o[k] == ($countones(in_sel_o[k*N_IN +: N_IN]) == 1));
  end

endmodule

// File: tb/tb_xpt_ctrl.sv
module tb_xpt_ctrl;

  localparam int N_OUT = 16;
  localparam int N_IN  = 32;
  localparam int W     = 6;
  localparam int HOLD  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic mode_ser_i = 1'b1, ser_clk_i = 1'b1, ser_di_i = 1'b0;
  logic wr_n_i = 1'b1, upd_n_i = 1'b1, clr_n_i = 1'b1;
  logic [3:0] wr_addr_i = '0;
  logic [W-1:0] wr_word_i = '0;
  logic ser_do_o;
  logic [N_OUT*N_IN-1:0] in_sel_o;
  logic [N_OUT-1:0] out_en_o;

  xpt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_ser_i(mode_ser_i), .ser_clk_i(ser_clk_i),
    .ser_di_i(ser_di_i), .ser_do_o(ser_do_o), .wr_n_i(wr_n_i),
    .wr_addr_i(wr_addr_i), .wr_word_i(wr_word_i), .upd_n_i(upd_n_i),
    .clr_n_i(clr_n_i), .in_sel_o(in_sel_o), .out_en_o(out_en_o));

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [W-1:0] exp_first [N_OUT];
  logic [W-1:0] exp_live  [N_OUT];

  typedef struct { int idx; logic [W-1:0] word; } exp_item_t;
  exp_item_t exp_q [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected words and compares against the decoded outputs.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() != 0) begin
        exp_item_t it;
        logic [N_IN-1:0] want;
        it = exp_q.pop_front();
        want = it.word[W-1] ? (N_IN'(1) << it.word[W-2:0]) : '0;
        chk(in_sel_o[it.idx*N_IN +: N_IN] == want, cur_tag, $sformatf("sel[%0d]", it.idx),
            64'(in_sel_o[it.idx*N_IN +: N_IN]), 64'(want));
        chk(out_en_o[it.idx] == it.word[W-1], cur_tag, $sformatf("en[%0d]", it.idx),
            64'(out_en_o[it.idx]), 64'(it.word[W-1]));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_live(input string tag);
    cur_tag = tag;
    for (int k = 0; k < N_OUT; k++) begin
      exp_item_t it;
      it.idx = k;
      it.word = exp_live[k];
      exp_q.push_back(it);
    end
    wait_clk(2);
  endtask

  task automatic ser_bit(input logic b);
    ser_di_i = b;
    wait_clk(HOLD);
    ser_clk_i = 1'b0;
    wait_clk(HOLD);
    ser_clk_i = 1'b1;
    wait_clk(HOLD);
  endtask

  // Stream position j carries word (15 - j/6), bit (5 - j%6).
  function automatic logic stream_bit(input logic [W-1:0] w [N_OUT], input int j);
    return w[N_OUT-1 - j/W][W-1 - j%W];
  endfunction

  task automatic ser_load(input logic [W-1:0] w [N_OUT], input bit track,
                          input logic [W-1:0] prev [N_OUT]);
    for (int j = 0; j < N_OUT*W; j++) begin
      if (track)
        chk(ser_do_o == stream_bit(prev, j), "R3", $sformatf("ser_do bit %0d", j),
            64'(ser_do_o), 64'(stream_bit(prev, j)));
      ser_bit(stream_bit(w, j));
    end
    if (mode_ser_i) for (int k = 0; k < N_OUT; k++) exp_first[k] = w[k];
  endtask

  task automatic par_write(input int a, input logic [W-1:0] d);
    wr_addr_i = 4'(a);
    wr_word_i = d;
    wait_clk(HOLD);
    wr_n_i = 1'b0;
    wait_clk(HOLD);
    wr_n_i = 1'b1;
    wait_clk(HOLD);
    if (!mode_ser_i) exp_first[a] = d;
  endtask

  task automatic pulse_upd();
    upd_n_i = 1'b0;
    wait_clk(6);
    upd_n_i = 1'b1;
    wait_clk(HOLD);
    for (int k = 0; k < N_OUT; k++) exp_live[k] = exp_first[k];
  endtask

  logic [W-1:0] pat_a [N_OUT];
  logic [W-1:0] pat_b [N_OUT];
  logic [W-1:0] zeros [N_OUT];

  initial begin
    for (int k = 0; k < N_OUT; k++) begin
      exp_first[k] = '0;
      exp_live[k]  = '0;
      zeros[k]     = '0;
      pat_a[k]     = {1'b1, 5'(2*k + 1)};
      pat_b[k]     = (k % 2 == 0) ? {1'b1, 5'(31 - k)} : 6'(k + 3);
    end

    // R1: reset state, during and after reset
    wait_clk(5);
    chk(out_en_o == '0 && in_sel_o == '0, "R1", "outputs in reset",
        64'(out_en_o), 64'(0));
    rst_n = 1'b1;
    wait_clk(5);
    chk(ser_do_o == 1'b0, "R1", "ser_do after reset", 64'(ser_do_o), 64'(0));
    expect_live("R1");

    // R2: serial load, not yet transferred (R6 hold), then transferred
    mode_ser_i = 1'b1;
    wait_clk(HOLD);
    ser_load(pat_a, 1'b0, zeros);
    expect_live("R6");
    pulse_upd();
    expect_live("R2");

    // R3: second stream pushes the first one out on ser_do
    ser_load(pat_b, 1'b1, pat_a);
    expect_live("R6");
    pulse_upd();
    expect_live("R8");

    // R4: addressed writes to single words, edge addresses and indices
    mode_ser_i = 1'b0;
    wait_clk(HOLD);
    par_write(3, {1'b1, 5'd31});
    par_write(15, {1'b1, 5'd0});
    par_write(0, 6'b0_10101);
    pulse_upd();
    expect_live("R4");

    // R5: serial edges ignored in parallel mode
    for (int j = 0; j < 8; j++) ser_bit(j[0]);
    pulse_upd();
    expect_live("R5");

    // R5: write strobe ignored in serial mode
    mode_ser_i = 1'b1;
    wait_clk(HOLD);
    par_write(5, {1'b1, 5'd7});
    pulse_upd();
    expect_live("R5");

    // R6: live follows while transfer held low, holds once high
    mode_ser_i = 1'b0;
    wait_clk(HOLD);
    upd_n_i = 1'b0;
    par_write(7, {1'b1, 5'd12});
    wait_clk(HOLD);
    for (int k = 0; k < N_OUT; k++) exp_live[k] = exp_first[k];
    expect_live("R6");
    upd_n_i = 1'b1;
    wait_clk(HOLD);
    par_write(7, {1'b1, 5'd20});
    par_write(9, 6'd0);
    expect_live("R6");
    pulse_upd();
    expect_live("R6");

    // R7: clear disables everything, even with transfer low
    upd_n_i = 1'b0;
    clr_n_i = 1'b0;
    wait_clk(HOLD + 2);
    for (int k = 0; k < N_OUT; k++) begin
      exp_first[k] = '0;
      exp_live[k]  = '0;
    end
    expect_live("R7");
    chk(ser_do_o == 1'b0, "R7", "ser_do in clear", 64'(ser_do_o), 64'(0));
    clr_n_i = 1'b1;
    upd_n_i = 1'b1;
    wait_clk(HOLD);
    pulse_upd();
    expect_live("R7");

    // R9 with a fresh load after clear
    par_write(11, {1'b1, 5'd17});
    par_write(12, 6'b0_11111);
    pulse_upd();
    expect_live("R9");

    wait_clk(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule